// File: doc/BRIEF.md
# Seven-Channel Peripheral Transfer Engine

This block moves bytes between an on-chip data RAM and a small set of peripheral data registers without processor involvement. Each of its seven channels is bound to one of six peripheral request sources. The chosen source also fixes the transfer direction: some sources fill a peripheral register from RAM, and others drain a peripheral register into RAM. A channel holds a 16-bit RAM base, a 16-bit running offset and a 16-bit byte count. It moves one byte per grant, with a read cycle followed by a write cycle, until the programmed count has gone.

Software programs the engine through a byte-wide register bus. A channel-select register points a register window at one channel. Shared registers hold enable, busy, two sets of completion flags (half and full) and an interrupt mask. The two I2C sources are mutually exclusive across enabled channels. The engine refuses an enable that would break this rule.

Top module: `pdma_engine`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `ram_we`, `ram_re`, `per_we` and `per_ack` are all inactive.
- R2: Register map at `reg_addr`: 0 enable, 1 busy (read only), 2 half flags, 3 full flags, 4 mask, 5 select, 8 source (bits 2:0), 9/A base low/high, B/C offset low/high, D/E size low/high. Bit n of registers 0 to 4 is channel n. Window addresses 8 to E reach the channel named by select. When select is 7 (no such channel), they read 0 and ignore writes.
- R3: Sources 0 (operand A load), 1 (operand B load), 2 (accumulator load) and 5 (I2C transmit) move data from RAM to the peripheral. A beat reads RAM at base+offset and then writes that byte with `per_we` and `per_sel` equal to the source code. `per_ack` bit [source] pulses during the write.
- R4: Sources 3 (accumulator store) and 4 (I2C receive) move data from the peripheral to RAM. A beat samples `per_rdata` while `per_sel` shows the source, then writes that byte to RAM at base+offset with `ram_we`.
- R5: The offset grows by one after each byte. After a full run it reads its start value plus the size.
- R6: When several channels are eligible, the lowest-numbered one is granted. A channel is eligible when it is enabled, its size is nonzero, it is not complete and its source's request input is high.
- R7: The half flag of a channel sets when its byte count since enabling reaches size/2 (rounded down, only if nonzero). The full flag sets when the count reaches size, and at that point the enable bit clears. The busy bit reads 1 while a channel is enabled with a nonzero size.
- R8: `irq` is high while any channel has a half or full flag set with its mask bit set. Writing 1 to a flag bit clears it.
- R9: An enable write that would leave one channel on source 4 and another on source 5 both enabled refuses the channels that break the rule. A channel that is already enabled keeps its place. If both sources are newly enabled in the same write, the source of the lowest-numbered new one is kept.
- R10: A channel with size 0, or with source code 6 or 7, never transfers and sets no flag.
- R11: Writes to the source field of an enabled channel are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| per_req | input | 6 | Request per peripheral source |
| per_ack | output | 6 | One-cycle acknowledge per source, in the write cycle of a beat |
| per_sel | output | 3 | Source code of the current beat |
| per_we | output | 1 | Peripheral register write strobe |
| per_wdata | output | 8 | Data to the peripheral |
| per_rdata | input | 8 | Data from the selected peripheral |
| ram_addr | output | 16 | RAM address |
| ram_re | output | 1 | RAM read strobe; data returns the next cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a RAM whose read data is valid in the cycle after `ram_re`. They also assume that software does not reprogram a channel's offset or size while one of its beats is in flight. The bench's RAM model has exactly this one-cycle latency. The bench writes channel registers only while every request line is low or the channel is disabled. It starts each transfer by writing the enable register last, and it lowers a request only at a falling edge, so no beat is ever cut short.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int NSRC   = 6;
  localparam int SRC_W  = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [SRC_W-1:0]  src_t;

  localparam src_t SRC_OPA    = 3'd0;
  localparam src_t SRC_OPB    = 3'd1;
  localparam src_t SRC_ACC_LD = 3'd2;
  localparam src_t SRC_ACC_ST = 3'd3;
  localparam src_t SRC_I2C_RX = 3'd4;
  localparam src_t SRC_I2C_TX = 3'd5;

  localparam logic [3:0] RA_EN    = 4'h0;
  localparam logic [3:0] RA_BUSY  = 4'h1;
  localparam logic [3:0] RA_HALF  = 4'h2;
  localparam logic [3:0] RA_FULL  = 4'h3;
  localparam logic [3:0] RA_MASK  = 4'h4;
  localparam logic [3:0] RA_SEL   = 4'h5;
  localparam logic [3:0] RA_SRC   = 4'h8;
  localparam logic [3:0] RA_BASEL = 4'h9;
  localparam logic [3:0] RA_BASEH = 4'hA;
  localparam logic [3:0] RA_OFFL  = 4'hB;
  localparam logic [3:0] RA_OFFH  = 4'hC;
  localparam logic [3:0] RA_SIZEL = 4'hD;
  localparam logic [3:0] RA_SIZEH = 4'hE;

  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR} mv_state_t;

  // true when the source drains a peripheral register into RAM
  function automatic logic src_to_ram(src_t s);
    return (s == SRC_ACC_ST) || (s == SRC_I2C_RX);
  endfunction

  function automatic logic src_valid(src_t s);
    return 32'(s) < NSRC;
  endfunction

  function automatic addr_t beat_addr(addr_t base, addr_t off);
    return base + off;
  endfunction

  function automatic addr_t half_mark(addr_t size);
    return size >> 1;
  endfunction

endpackage

// File: rtl/pdma_arb.sv
module pdma_arb #(
  parameter int NCH = 7,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  output logic           gnt_vld,
  output logic [CW-1:0]  gnt_idx
);
  // fixed priority: scan from the top so the lowest eligible index is left last
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (elig[c]) begin
        gnt_vld = 1'b1;
        gnt_idx = CW'(c);
      end
    end
  end
endmodule

// File: rtl/pdma_mover.sv
module pdma_mover
  import pdma_pkg::*;
#(
  parameter int NCH = 7,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gnt_vld,
  input  logic [CW-1:0]   gnt_idx,
  output logic [CW-1:0]   mv_ch,
  input  src_t            mv_src,
  input  addr_t           mv_addr,
  output logic [NSRC-1:0] per_ack,
  output src_t            per_sel,
  output logic            per_we,
  output byte_t           per_wdata,
  input  byte_t           per_rdata,
  output addr_t           ram_addr,
  output logic            ram_re,
  output logic            ram_we,
  output byte_t           ram_wdata,
  input  byte_t           ram_rdata,
  output logic            beat_done,
  output logic [CW-1:0]   beat_ch
);
  mv_state_t      state_q;
  logic [CW-1:0]  ch_q;
  src_t           src_q;
  addr_t          addr_q;
  byte_t          hold_q;
  logic           dir_ram;

  assign dir_ram = src_to_ram(src_q);
  assign mv_ch   = (state_q == MV_IDLE) ? gnt_idx : ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      ch_q    <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      hold_q  <= '0;
    end else begin
      case (state_q)
        MV_IDLE: if (gnt_vld) begin
          ch_q    <= gnt_idx;
          src_q   <= mv_src;
          addr_q  <= mv_addr;
          state_q <= MV_RD;
        end
        MV_RD: begin
          if (dir_ram) hold_q <= per_rdata;
          state_q <= MV_WR;
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_re    = (state_q == MV_RD) && !dir_ram;
    ram_we    = (state_q == MV_WR) && dir_ram;
    per_we    = (state_q == MV_WR) && !dir_ram;
    ram_addr  = addr_q;
    ram_wdata = hold_q;
    per_wdata = ram_rdata;
    per_sel   = src_q;
    beat_done = (state_q == MV_WR);
    beat_ch   = ch_q;
    per_ack   = '0;
    if (state_q == MV_WR && src_valid(src_q)) per_ack[src_q] = 1'b1;
  end

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, per_we}));
  assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_ack));
  assert_ack_with_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack != '0) |-> (ram_we || per_we));
  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> per_we);
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int NCH = 7,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wen,
  input  logic [3:0]      reg_addr,
  input  byte_t           reg_wdata,
  output byte_t           reg_rdata,
  input  logic [NSRC-1:0] per_req,
  output logic [NCH-1:0]  elig,
  input  logic [CW-1:0]   mv_ch,
  output src_t            mv_src,
  output addr_t           mv_addr,
  input  logic            beat_done,
  input  logic [CW-1:0]   beat_ch,
  output logic            irq
);
  logic [NCH-1:0] en_q, half_q, full_q, mask_q;
  logic [CW-1:0]  sel_q;
  src_t           src_q  [NCH];
  addr_t          base_q [NCH];
  addr_t          off_q  [NCH];
  addr_t          size_q [NCH];
  addr_t          cnt_q  [NCH];

  logic [NCH-1:0] is_rx, is_tx, size_nz, busy, en_wr;
  logic [7:0]     req_pad;
  logic           sel_ok, win_wr;
  addr_t          new_cnt, beat_size;
  logic           half_evt, full_evt;

  assign req_pad = 8'(per_req);
  assign sel_ok  = 32'(sel_q) < NCH;
  assign win_wr  = reg_wen && reg_addr[3] && sel_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign is_rx[c]   = src_q[c] == SRC_I2C_RX;
    assign is_tx[c]   = src_q[c] == SRC_I2C_TX;
    assign size_nz[c] = size_q[c] != '0;
    assign busy[c]    = en_q[c] && size_nz[c];
    assign elig[c]    = en_q[c] && size_nz[c] && (cnt_q[c] != size_q[c])
                        && src_valid(src_q[c]) && req_pad[src_q[c]];
  end

  // enable write filtered so that I2C receive and transmit never coexist
  always_comb begin
    logic [NCH-1:0] want, kept, fresh;
    logic pick_rx, pick_tx, found;
    want    = reg_wdata[NCH-1:0];
    kept    = en_q & want;
    fresh   = want & ~en_q;
    pick_rx = |(kept & is_rx);
    pick_tx = |(kept & is_tx);
    found   = pick_rx || pick_tx;
    for (int c = 0; c < NCH; c++) begin
      if (!found && fresh[c] && (is_rx[c] || is_tx[c])) begin
        found   = 1'b1;
        pick_rx = is_rx[c];
        pick_tx = is_tx[c];
      end
    end
    en_wr = kept | (fresh & ~(pick_rx ? is_tx : '0) & ~(pick_tx ? is_rx : '0));
  end

  assign mv_src    = (32'(mv_ch) < NCH) ? src_q[mv_ch] : '0;
  assign mv_addr   = (32'(mv_ch) < NCH) ? beat_addr(base_q[mv_ch], off_q[mv_ch]) : '0;
  assign beat_size = (32'(beat_ch) < NCH) ? size_q[beat_ch] : '0;
  assign new_cnt   = ((32'(beat_ch) < NCH) ? cnt_q[beat_ch] : '0) + 1'b1;
  assign half_evt  = beat_done && half_mark(beat_size) != '0 && new_cnt == half_mark(beat_size);
  assign full_evt  = beat_done && new_cnt == beat_size;
  assign irq       = |((half_q | full_q) & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; half_q <= '0; full_q <= '0; mask_q <= '0; sel_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        src_q[c] <= '0; base_q[c] <= '0; off_q[c] <= '0;
        size_q[c] <= '0; cnt_q[c] <= '0;
      end
    end else begin
      if (reg_wen) begin
        case (reg_addr)
          RA_EN: begin
            en_q <= en_wr;
            for (int c = 0; c < NCH; c++)
              if (en_wr[c] && !en_q[c]) cnt_q[c] <= '0;
          end
          RA_HALF: half_q <= half_q & ~reg_wdata[NCH-1:0];
          RA_FULL: full_q <= full_q & ~reg_wdata[NCH-1:0];
          RA_MASK: mask_q <= reg_wdata[NCH-1:0];
          RA_SEL:  sel_q  <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (win_wr) begin
        case (reg_addr)
          RA_SRC:   if (!en_q[sel_q]) src_q[sel_q] <= reg_wdata[SRC_W-1:0];
          RA_BASEL: base_q[sel_q][7:0]  <= reg_wdata;
          RA_BASEH: base_q[sel_q][15:8] <= reg_wdata;
          RA_OFFL:  off_q[sel_q][7:0]   <= reg_wdata;
          RA_OFFH:  off_q[sel_q][15:8]  <= reg_wdata;
          RA_SIZEL: size_q[sel_q][7:0]  <= reg_wdata;
          RA_SIZEH: size_q[sel_q][15:8] <= reg_wdata;
          default: ;
        endcase
      end
      if (beat_done && 32'(beat_ch) < NCH) begin
        cnt_q[beat_ch] <= new_cnt;
        off_q[beat_ch] <= off_q[beat_ch] + 1'b1;
        if (half_evt) half_q[beat_ch] <= 1'b1;
        if (full_evt) begin
          full_q[beat_ch] <= 1'b1;
          en_q[beat_ch]   <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_EN:   reg_rdata = 8'(en_q);
      RA_BUSY: reg_rdata = 8'(busy);
      RA_HALF: reg_rdata = 8'(half_q);
      RA_FULL: reg_rdata = 8'(full_q);
      RA_MASK: reg_rdata = 8'(mask_q);
      RA_SEL:  reg_rdata = 8'(sel_q);
      default: if (sel_ok) begin
        case (reg_addr)
          RA_SRC:   reg_rdata = 8'(src_q[sel_q]);
          RA_BASEL: reg_rdata = base_q[sel_q][7:0];
          RA_BASEH: reg_rdata = base_q[sel_q][15:8];
          RA_OFFL:  reg_rdata = off_q[sel_q][7:0];
          RA_OFFH:  reg_rdata = off_q[sel_q][15:8];
          RA_SIZEL: reg_rdata = size_q[sel_q][7:0];
          RA_SIZEH: reg_rdata = size_q[sel_q][15:8];
          default:  reg_rdata = '0;
        endcase
      end
    endcase
  end

  assert_i2c_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(en_q & is_rx)) && (|(en_q & is_tx))));
  assert_full_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> !en_q[$past(beat_ch)]);
  assert_zero_size_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> beat_size != '0);
  assert_offset_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !(win_wr && sel_q == beat_ch)) |=>
      off_q[$past(beat_ch)] == $past(off_q[beat_ch]) + 1'b1);
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int NCH = 7,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wen,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [5:0]  per_req,
  output logic [5:0]  per_ack,
  output logic [2:0]  per_sel,
  output logic        per_we,
  output logic [7:0]  per_wdata,
  input  logic [7:0]  per_rdata,
  output logic [15:0] ram_addr,
  output logic        ram_re,
  output logic        ram_we,
  output logic [7:0]  ram_wdata,
  input  logic [7:0]  ram_rdata,
  output logic        irq
);
  logic [NCH-1:0] elig;
  logic           gnt_vld, beat_done;
  logic [CW-1:0]  gnt_idx, mv_ch, beat_ch;
  src_t           mv_src;
  addr_t          mv_addr;

  pdma_regs #(.NCH(NCH)) u_regs (
    .clk, .rst_n, .reg_wen, .reg_addr, .reg_wdata, .reg_rdata,
    .per_req, .elig, .mv_ch, .mv_src, .mv_addr,
    .beat_done, .beat_ch, .irq
  );

  pdma_arb #(.NCH(NCH)) u_arb (
    .elig, .gnt_vld, .gnt_idx
  );

  pdma_mover #(.NCH(NCH)) u_mover (
    .clk, .rst_n, .gnt_vld, .gnt_idx, .mv_ch, .mv_src, .mv_addr,
    .per_ack, .per_sel, .per_we, .per_wdata, .per_rdata,
    .ram_addr, .ram_re, .ram_we, .ram_wdata, .ram_rdata,
    .beat_done, .beat_ch
  );

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (elig[gnt_idx] && (elig & ~({NCH{1'b1}} << gnt_idx)) == '0));
  assert_no_grant_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !gnt_vld);
endmodule

// File: tb/test_pdma_engine.sv
`timescale 1ns/100ps
module test_pdma_engine;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wen = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [5:0]  per_req = 0;
  logic [5:0]  per_ack;
  logic [2:0]  per_sel;
  logic        per_we, ram_re, ram_we, irq;
  logic [7:0]  per_wdata, per_rdata, ram_wdata;
  logic [7:0]  ram_rdata = 0;
  logic [15:0] ram_addr;
  logic [7:0]  rx_cnt = 0;
  logic [7:0]  mem [0:4095];

  int nchk = 0;
  int nerr = 0;

  typedef struct {bit to_ram; logic [15:0] addr; logic [2:0] sel; logic [7:0] data;} item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  pdma_engine i_pdma_engine (
    .clk, .rst_n, .reg_wen, .reg_addr, .reg_wdata, .reg_rdata,
    .per_req, .per_ack, .per_sel, .per_we, .per_wdata, .per_rdata,
    .ram_addr, .ram_re, .ram_we, .ram_wdata, .ram_rdata, .irq
  );

  assign per_rdata = 8'h30 + rx_cnt;

  always @(posedge clk) begin
    if (ram_re) ram_rdata <= mem[ram_addr[11:0]];
    if (ram_we) begin
      mem[ram_addr[11:0]] <= ram_wdata;
      rx_cnt <= rx_cnt + 8'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (ram_we || per_we)) begin
      if (sb.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R10: unexpected beat got ram_we=%b per_we=%b expected none", ram_we, per_we);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.to_ram) begin
          chk("R4 dir", {31'd0, ram_we}, 32'd1);
          chk("R4 addr", {16'd0, ram_addr}, {16'd0, it.addr});
          chk("R4 data", {24'd0, ram_wdata}, {24'd0, it.data});
        end else begin
          chk("R3 dir", {31'd0, per_we}, 32'd1);
          chk("R3 sel", {29'd0, per_sel}, {29'd0, it.sel});
          chk("R3 data", {24'd0, per_wdata}, {24'd0, it.data});
          chk("R3 ack", {26'd0, per_ack}, 32'd1 << it.sel);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, {24'd0, v}, {24'd0, exp});
  endtask

  task automatic setup(input int ch, input logic [2:0] src, input logic [15:0] base,
                       input logic [15:0] off, input logic [15:0] size);
    wr(4'h5, 8'(ch)); wr(4'h8, 8'(src));
    wr(4'h9, base[7:0]); wr(4'hA, base[15:8]);
    wr(4'hB, off[7:0]);  wr(4'hC, off[15:8]);
    wr(4'hD, size[7:0]); wr(4'hE, size[15:8]);
  endtask

  task automatic push_out(input logic [2:0] src, input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.to_ram = 0; it.sel = src; it.addr = a + 16'(i); it.data = mem[it.addr[11:0]];
      sb.push_back(it);
    end
  endtask

  task automatic push_in(input logic [15:0] a, input logic [7:0] first, input int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.to_ram = 1; it.sel = 0; it.addr = a + 16'(i); it.data = 8'h30 + first + 8'(i);
      sb.push_back(it);
    end
  endtask

  task automatic wait_off(input logic [7:0] m);
    logic [7:0] v;
    for (int k = 0; k < 500; k++) begin
      rd(4'h0, v);
      if ((v & m) == 0) break;
    end
    chk("R7 completion", {24'd0, v & m}, 32'd0);
    chk("R3 scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int acks;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 strobes", {22'd0, ram_we, ram_re, per_we, per_ack}, 0);
    rst_n = 1;
    for (int a = 0; a < 15; a++) if (a != 6 && a != 7) rdchk("R1 reg", 4'(a), 8'h00);

    // R2 window select
    wr(4'h5, 8'd7); wr(4'h9, 8'h77);
    rdchk("R2 absent channel", 4'h9, 8'h00);
    wr(4'h5, 8'd6); wr(4'h9, 8'h5A);
    rdchk("R2 window", 4'h9, 8'h5A);
    wr(4'h9, 8'h00);

    // R3 RAM to peripheral, source 0
    setup(0, 3'd0, 16'h0100, 16'h0000, 16'd4);
    push_out(3'd0, 16'h0100, 4);
    per_req = 6'b000001;
    wr(4'h0, 8'h01);
    wait_off(8'h01);
    per_req = 0;
    wr(4'h5, 8'd0);
    rdchk("R5 offset end", 4'hB, 8'd4);
    rdchk("R7 half set", 4'h2, 8'h01);
    rdchk("R7 full set", 4'h3, 8'h01);
    rdchk("R7 busy clear", 4'h1, 8'h00);
    wr(4'h2, 8'hFF); wr(4'h3, 8'hFF);

    // R4 peripheral to RAM, source 4, offset starting at 3
    setup(2, 3'd4, 16'h0200, 16'h0003, 16'd5);
    push_in(16'h0203, rx_cnt, 5);
    per_req = 6'b010000;
    wr(4'h0, 8'h04);
    wait_off(8'h04);
    per_req = 0;
    rdchk("R5 offset start plus size", 4'hB, 8'd8);
    chk("R4 ram content", {24'd0, mem[12'h207]}, 32'h34);
    wr(4'h2, 8'hFF); wr(4'h3, 8'hFF);

    // R6 lowest channel first
    setup(1, 3'd1, 16'h0300, 16'h0000, 16'd3);
    setup(3, 3'd2, 16'h0400, 16'h0000, 16'd2);
    push_out(3'd1, 16'h0300, 3);
    push_out(3'd2, 16'h0400, 2);
    per_req = 6'b000110;
    wr(4'h0, 8'h0A);
    wait_off(8'h0A);
    per_req = 0;
    wr(4'h2, 8'hFF); wr(4'h3, 8'hFF);

    // R7 half without full, R8 interrupt
    setup(5, 3'd5, 16'h0500, 16'h0000, 16'd6);
    push_out(3'd5, 16'h0500, 3);
    per_req = 6'b100000;
    wr(4'h0, 8'h20);
    acks = 0;
    while (acks < 3) begin
      @(negedge clk);
      if (per_ack[5]) acks++;
    end
    per_req = 0;
    repeat (6) @(negedge clk);
    chk("R7 half-only beats", sb.size(), 0);
    rdchk("R7 half at size/2", 4'h2, 8'h20);
    rdchk("R7 no full yet", 4'h3, 8'h00);
    rdchk("R7 still enabled", 4'h0, 8'h20);
    rdchk("R7 busy", 4'h1, 8'h20);
    chk("R8 masked off", {31'd0, irq}, 0);
    wr(4'h4, 8'h20);
    #1 chk("R8 irq on", {31'd0, irq}, 1);
    wr(4'h2, 8'h20);
    #1 chk("R8 w1c clears", {31'd0, irq}, 0);
    wr(4'h0, 8'h00); wr(4'h4, 8'h00);

    // R9 I2C exclusion
    setup(4, 3'd4, 16'h0000, 16'h0000, 16'd0);
    setup(6, 3'd5, 16'h0000, 16'h0000, 16'd0);
    wr(4'h0, 8'h10); wr(4'h0, 8'h50);
    rdchk("R9 refuse second", 4'h0, 8'h10);
    wr(4'h0, 8'h00); wr(4'h0, 8'h50);
    rdchk("R9 simultaneous", 4'h0, 8'h10);

    // R11 source locked while enabled
    wr(4'h5, 8'd4); wr(4'h8, 8'd1);
    rdchk("R11 locked", 4'h8, 8'd4);
    wr(4'h0, 8'h00); wr(4'h8, 8'd1);
    rdchk("R11 unlocked", 4'h8, 8'd1);

    // R10 zero size and invalid source
    wr(4'h5, 8'd0); wr(4'hD, 8'd0); wr(4'hE, 8'd0);
    per_req = 6'b000001;
    wr(4'h0, 8'h01);
    repeat (20) @(negedge clk);
    rdchk("R10 size0 stays enabled", 4'h0, 8'h01);
    rdchk("R10 size0 no half", 4'h2, 8'h00);
    rdchk("R10 size0 no full", 4'h3, 8'h00);
    rdchk("R10 size0 not busy", 4'h1, 8'h00);
    wr(4'h0, 8'h00);
    wr(4'h8, 8'd6); wr(4'hD, 8'd2);
    per_req = 6'h3F;
    wr(4'h0, 8'h01);
    repeat (20) @(negedge clk);
    rdchk("R10 bad source offset", 4'hB, 8'd4);
    rdchk("R10 bad source flags", 4'h3, 8'h00);
    per_req = 0;
    wr(4'h0, 8'h00);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule